// File: doc/BRIEF.md
# Multi-Domain Power Rail Sequencer

This block brings the supply rails of a board up in a fixed order and then watches them. A main sequencer turns on the 12 V rail, then the core and 3.3 V rails together, then the DDR rail, and each step waits for the power-good signal of the rail just enabled. Only after the main domain reports ready do three dependent domains start: the transceiver domain (three enables, three power-goods), the periphery domain (three enables, no power-good feedback) and the mezzanine-card domain (a parameterised group of enables and power-goods).

Every power-good pin and the already-debounced restart button pass through a two-flop synchronizer. A rail that drops after its domain reached ready sends the domain to a latched fault state. A wait state that lasts longer than a programmable number of cycles sends the domain to a separate latched timeout state. Only the restart button clears either state. Each domain exports a 3-bit state code for the status-indicator logic. The bring-up flow per domain is IDLE, RAMP1, (RAMP2 for main only), READY, with FAULT and TIMEOUT as the latched exits.

Top module: `rail_seq_top`

## Requirements
- R1: After reset all state codes are 0 (IDLE), the main enables read 4'b0001 (bit0 = 12 V, bit1 = core, bit2 = 3.3 V, bit3 = DDR), all dependent enables are 0 and `main_ready` is 0.
- R2: Main IDLE moves to RAMP1 (code 1) when the synchronized 12 V good (`pg_main[0]`) is high; in RAMP1 the main enables read 4'b0111.
- R3: Main RAMP1 moves to RAMP2 (code 2, enables 4'b1111) on the full-power-domain good (`pg_main[1]`); RAMP2 moves to READY (code 3, enables 4'b1111, `main_ready` = 1) on the DDR good (`pg_main[2]`).
- R4: In main READY the loss of any of the three main power-goods moves the main domain to FAULT (code 4) with all main enables 0, `rail_err[0]` = 1; FAULT holds when the power-goods return.
- R5: No dependent domain leaves IDLE or drives an enable while the main domain is not READY.
- R6: The transceiver domain drives its three enables together in RAMP1 (code 1) and enters READY (code 3) only when all three of `pg_xcvr` are high.
- R7: The periphery domain drives its three enables once main is READY and reaches READY one cycle after RAMP1 without checking any power-good.
- R8: The mezzanine domain follows the transceiver rules with its own power-goods; losing one after READY gives FAULT (code 4), enables 0, `rail_err[3]` = 1, held after the power-good returns.
- R9: A wait state lasting `TO_CYC` cycles without its advancing power-good moves the domain to TIMEOUT (code 5) with its enables 0 and `up_fail` set for that domain while `rail_err` stays 0 (bits: 0 main, 1 transceiver, 2 periphery, 3 mezzanine).
- R10: While the synchronized restart is high every domain is in IDLE; after release the full sequence runs again and clears earlier FAULT or TIMEOUT.
- R11: A power-good change reaches the state on the third rising clock edge after it is driven (two synchronizer flops plus the state register).
- R12: When the main domain leaves READY, dependent domains that are in RAMP1 or READY return to IDLE with their enables off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| restart_btn | input | 1 | Debounced restart button, active high, asynchronous |
| pg_main | input | 3 | Main power-goods: bit0 12 V, bit1 full-power domain, bit2 DDR |
| pg_xcvr | input | 3 | Transceiver power-goods |
| pg_fmc | input | NFMC_PG | Mezzanine-card power-goods |
| en_main | output | 4 | Main enables: bit0 12 V, bit1 core, bit2 3.3 V, bit3 DDR |
| en_xcvr | output | 3 | Transceiver enables |
| en_periph | output | 3 | Periphery enables |
| en_fmc | output | NFMC_EN | Mezzanine-card enables |
| st_main | output | 3 | Main state code |
| st_xcvr | output | 3 | Transceiver state code |
| st_periph | output | 3 | Periphery state code |
| st_fmc | output | 3 | Mezzanine state code |
| main_ready | output | 1 | Main domain in READY |
| up_fail | output | 4 | Per-domain timeout flag |
| rail_err | output | 4 | Per-domain fault-after-ready flag |

## Verification
A wrong state register shows immediately as a wrong state code and enable pattern on the same cycle, because both are decoded straight from the state. A wrong transition shows at the latest three edges after the power-good change that should have caused it, the synchronizer depth plus one, so the bench samples a few cycles after each stimulus and once at the exact third edge. A counter that never expires or expires early shows as a missing or premature TIMEOUT code within `TO_CYC` cycles of entering a wait state.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;
    typedef enum logic [2:0] {
        PS_IDLE  = 3'd0,
        PS_RAMP1 = 3'd1,
        PS_RAMP2 = 3'd2,
        PS_READY = 3'd3,
        PS_FAULT = 3'd4,
        PS_TMO   = 3'd5
    } pstate_t;
endpackage

// File: rtl/pg_sync.sv
module pg_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/main_seq.sv
module main_seq
    import pwrseq_pkg::*;
#(
    parameter int TO_CYC = 1000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       restart,
    input  logic [2:0] pg,
    output logic [3:0] en,
    output logic [2:0] st,
    output logic       ready,
    output logic       upfail,
    output logic       railerr
);
    localparam int CW = $clog2(TO_CYC + 1);

    pstate_t       cur, nxt;
    logic [CW-1:0] cnt;
    logic          waiting, tmo;

    assign waiting = (cur == PS_IDLE) || (cur == PS_RAMP1) || (cur == PS_RAMP2);
    assign tmo     = waiting && (cnt == CW'(TO_CYC - 1));

    always_comb begin
        nxt = cur;
        unique case (cur)
            PS_IDLE:  if (pg[0]) nxt = PS_RAMP1; else if (tmo) nxt = PS_TMO;
            PS_RAMP1: if (pg[1]) nxt = PS_RAMP2; else if (tmo) nxt = PS_TMO;
            PS_RAMP2: if (pg[2]) nxt = PS_READY; else if (tmo) nxt = PS_TMO;
            PS_READY: if (!(&pg)) nxt = PS_FAULT;
            PS_FAULT: nxt = PS_FAULT;
            PS_TMO:   nxt = PS_TMO;
            default:  nxt = PS_IDLE;
        endcase
        if (restart) nxt = PS_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur <= PS_IDLE;
            cnt <= '0;
        end else begin
            cur <= nxt;
            if (restart || !waiting || (nxt != cur)) cnt <= '0;
            else                                     cnt <= cnt + 1'b1;
        end
    end

    always_comb begin
        unique case (cur)
            PS_IDLE:  en = 4'b0001;
            PS_RAMP1: en = 4'b0111;
            PS_RAMP2: en = 4'b1111;
            PS_READY: en = 4'b1111;
            default:  en = 4'b0000;
        endcase
        st      = cur;
        ready   = (cur == PS_READY);
        upfail  = (cur == PS_TMO);
        railerr = (cur == PS_FAULT);
    end

    // R3
    ready_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (en == 4'b1111));
    // R10
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (st == 3'd0));
    // R4
    fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (railerr && !restart) |=> railerr);
    // R9
    main_cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < CW'(TO_CYC));
endmodule

// File: rtl/dom_seq.sv
module dom_seq
    import pwrseq_pkg::*;
#(
    parameter int NPG    = 3,
    parameter int NEN    = 3,
    parameter int TO_CYC = 1000,
    localparam int PGW   = (NPG == 0) ? 1 : NPG
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           go,
    input  logic           restart,
    input  logic [PGW-1:0] pg,
    output logic [NEN-1:0] en,
    output logic [2:0]     st,
    output logic           upfail,
    output logic           railerr
);
    localparam int CW = $clog2(TO_CYC + 1);

    pstate_t       cur, nxt;
    logic [CW-1:0] cnt;
    logic          pg_all, waiting, tmo;

    generate
        if (NPG == 0) begin : g_nopg
            logic pg_unused_ok;
            assign pg_unused_ok = ^pg;
            assign pg_all       = 1'b1;
        end else begin : g_pg
            assign pg_all = &pg;
        end
    endgenerate

    assign waiting = (cur == PS_RAMP1);
    assign tmo     = waiting && (cnt == CW'(TO_CYC - 1));

    always_comb begin
        nxt = cur;
        unique case (cur)
            PS_IDLE:  if (go) nxt = PS_RAMP1;
            PS_RAMP1: if (!go) nxt = PS_IDLE;
                      else if (pg_all) nxt = PS_READY;
                      else if (tmo) nxt = PS_TMO;
            PS_READY: if (!go) nxt = PS_IDLE;
                      else if (!pg_all) nxt = PS_FAULT;
            PS_FAULT: nxt = PS_FAULT;
            PS_TMO:   nxt = PS_TMO;
            default:  nxt = PS_IDLE;
        endcase
        if (restart) nxt = PS_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur <= PS_IDLE;
            cnt <= '0;
        end else begin
            cur <= nxt;
            if (restart || !waiting || (nxt != cur)) cnt <= '0;
            else                                     cnt <= cnt + 1'b1;
        end
    end

    always_comb begin
        unique case (cur)
            PS_RAMP1, PS_READY: en = '1;
            default:            en = '0;
        endcase
        st      = cur;
        upfail  = (cur == PS_TMO);
        railerr = (cur == PS_FAULT);
    end

    // R5
    gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !go |=> (en == '0));
    // R6
    rdy_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (waiting && !pg_all) |=> (st != 3'd3));
    // R9
    dom_cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < CW'(TO_CYC));
    // R8
    dom_fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (railerr && !restart) |=> railerr);
endmodule

// File: rtl/rail_seq_top.sv
module rail_seq_top #(
    parameter int TO_CYC  = 1000,
    parameter int NFMC_PG = 3,
    parameter int NFMC_EN = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               restart_btn,
    input  logic [2:0]         pg_main,
    input  logic [2:0]         pg_xcvr,
    input  logic [NFMC_PG-1:0] pg_fmc,
    output logic [3:0]         en_main,
    output logic [2:0]         en_xcvr,
    output logic [2:0]         en_periph,
    output logic [NFMC_EN-1:0] en_fmc,
    output logic [2:0]         st_main,
    output logic [2:0]         st_xcvr,
    output logic [2:0]         st_periph,
    output logic [2:0]         st_fmc,
    output logic               main_ready,
    output logic [3:0]         up_fail,
    output logic [3:0]         rail_err
);
    localparam int SW = 1 + 3 + 3 + NFMC_PG;

    logic [SW-1:0]      sync_q;
    logic               restart_s;
    logic [2:0]         main_s, xcvr_s;
    logic [NFMC_PG-1:0] fmc_s;

    pg_sync #(.W(SW)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({restart_btn, pg_fmc, pg_xcvr, pg_main}),
        .q    (sync_q)
    );
    assign {restart_s, fmc_s, xcvr_s, main_s} = sync_q;

    main_seq #(.TO_CYC(TO_CYC)) u_main (
        .clk(clk), .rst_n(rst_n), .restart(restart_s), .pg(main_s),
        .en(en_main), .st(st_main), .ready(main_ready),
        .upfail(up_fail[0]), .railerr(rail_err[0])
    );

    dom_seq #(.NPG(3), .NEN(3), .TO_CYC(TO_CYC)) u_xcvr (
        .clk(clk), .rst_n(rst_n), .go(main_ready), .restart(restart_s),
        .pg(xcvr_s), .en(en_xcvr), .st(st_xcvr),
        .upfail(up_fail[1]), .railerr(rail_err[1])
    );

    dom_seq #(.NPG(0), .NEN(3), .TO_CYC(TO_CYC)) u_periph (
        .clk(clk), .rst_n(rst_n), .go(main_ready), .restart(restart_s),
        .pg(1'b0), .en(en_periph), .st(st_periph),
        .upfail(up_fail[2]), .railerr(rail_err[2])
    );

    dom_seq #(.NPG(NFMC_PG), .NEN(NFMC_EN), .TO_CYC(TO_CYC)) u_fmc (
        .clk(clk), .rst_n(rst_n), .go(main_ready), .restart(restart_s),
        .pg(fmc_s), .en(en_fmc), .st(st_fmc),
        .upfail(up_fail[3]), .railerr(rail_err[3])
    );
endmodule

// File: tb/test_rail_seq_top.sv
`timescale 1ns/1ps
module test_rail_seq_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       restart_btn = 1'b0;
    logic [2:0] pg_main = 3'b000, pg_xcvr = 3'b000, pg_fmc = 3'b000;
    logic [3:0] en_main;
    logic [2:0] en_xcvr, en_periph;
    logic [5:0] en_fmc;
    logic [2:0] st_main, st_xcvr, st_periph, st_fmc;
    logic       main_ready;
    logic [3:0] up_fail, rail_err;

    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    rail_seq_top #(.TO_CYC(40), .NFMC_PG(3), .NFMC_EN(6)) i_rail_seq_top (
        .clk(clk), .rst_n(rst_n), .restart_btn(restart_btn),
        .pg_main(pg_main), .pg_xcvr(pg_xcvr), .pg_fmc(pg_fmc),
        .en_main(en_main), .en_xcvr(en_xcvr), .en_periph(en_periph), .en_fmc(en_fmc),
        .st_main(st_main), .st_xcvr(st_xcvr), .st_periph(st_periph), .st_fmc(st_fmc),
        .main_ready(main_ready), .up_fail(up_fail), .rail_err(rail_err)
    );

    // {pg_main, expected st_main, expected en_main}
    localparam logic [9:0] MAIN_VEC [4] = '{
        {3'b000, 3'd0, 4'b0001},
        {3'b001, 3'd1, 4'b0111},
        {3'b011, 3'd2, 4'b1111},
        {3'b111, 3'd3, 4'b1111}
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        step(2);
        rst_n = 1'b1;
        step(1);
        // R1 reset state
        check("R1 st_main", st_main, 0);
        check("R1 en_main", en_main, 4'b0001);
        check("R1 dependents", {st_xcvr, st_periph, st_fmc}, 0);
        check("R1 dep enables", {en_xcvr, en_periph, en_fmc}, 0);
        check("R1 main_ready", main_ready, 0);

        // R2 R3 main bring-up table
        foreach (MAIN_VEC[i]) begin
            pg_main = MAIN_VEC[i][9:7];
            step(5);
            check("R2/R3 st_main", st_main, MAIN_VEC[i][6:4]);
            check("R2/R3 en_main", en_main, MAIN_VEC[i][3:0]);
            if (i == 2) begin
                // R5 dependents idle until main READY
                check("R5 st_xcvr", st_xcvr, 0);
                check("R5 en dep", {en_xcvr, en_periph, en_fmc}, 0);
            end
        end
        check("R3 main_ready", main_ready, 1);

        // R6 R7 R8 dependent start
        check("R6 st_xcvr ramp", st_xcvr, 1);
        check("R6 en_xcvr", en_xcvr, 3'b111);
        check("R7 st_periph", st_periph, 3);
        check("R7 en_periph", en_periph, 3'b111);
        check("R8 st_fmc ramp", st_fmc, 1);
        check("R8 en_fmc", en_fmc, 6'h3F);
        pg_xcvr = 3'b011;
        step(5);
        check("R6 partial pg holds", st_xcvr, 1);
        pg_xcvr = 3'b111;
        pg_fmc  = 3'b111;
        step(5);
        check("R6 xcvr ready", st_xcvr, 3);
        check("R8 fmc ready", st_fmc, 3);

        // R8 fault after ready
        pg_fmc = 3'b101;
        step(5);
        check("R8 fmc fault", st_fmc, 4);
        check("R8 en_fmc off", en_fmc, 0);
        check("R8 rail_err", rail_err[3], 1);
        check("R8 xcvr unaffected", st_xcvr, 3);
        pg_fmc = 3'b111;
        step(5);
        check("R8 fault latched", st_fmc, 4);

        // R10 restart
        restart_btn = 1'b1;
        pg_main = 3'b000;
        step(4);
        check("R10 all idle", {st_main, st_xcvr, st_periph, st_fmc}, 0);
        check("R10 en_main", en_main, 4'b0001);
        check("R10 fault cleared", rail_err, 0);
        restart_btn = 1'b0;
        step(4);
        check("R10 still idle", st_main, 0);

        // R11 synchronizer latency
        pg_main = 3'b001;
        @(posedge clk); @(posedge clk); @(negedge clk);
        check("R11 after two edges", st_main, 0);
        @(posedge clk); @(negedge clk);
        check("R11 third edge", st_main, 1);

        pg_main = 3'b111;
        step(10);
        check("R10 rerun main", st_main, 3);
        check("R10 rerun xcvr", st_xcvr, 3);
        check("R10 rerun fmc", st_fmc, 3);

        // R4 main fault, R12 dependents drop
        pg_main = 3'b011;
        step(5);
        check("R4 st_main", st_main, 4);
        check("R4 en_main", en_main, 0);
        check("R4 main_ready", main_ready, 0);
        check("R4 rail_err", rail_err[0], 1);
        check("R12 xcvr idle", st_xcvr, 0);
        check("R12 dep enables", {en_xcvr, en_periph, en_fmc}, 0);
        pg_main = 3'b111;
        step(5);
        check("R4 latched", st_main, 4);

        // R9 timeout
        restart_btn = 1'b1;
        pg_main = 3'b001;
        step(4);
        restart_btn = 1'b0;
        step(60);
        check("R9 st_main", st_main, 5);
        check("R9 en_main", en_main, 0);
        check("R9 up_fail", up_fail[0], 1);
        check("R9 rail_err clear", rail_err[0], 0);
        check("R9 xcvr idle", st_xcvr, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule